// File: doc/BRIEF.md
# Windowed Variable-Width Address Translator

This block maps a 16-bit address register value onto a 1024 x 32-bit block RAM. The two most significant address bits choose a window, and each window gives a view of the same memory with a different element width: 32, 16, 8 or 4 bits. Software picks an element width by choosing an address, so no special access instructions are needed. The block returns the physical word address, the lane of the element inside that word, and the decoded width.

Offset addressing is done with an XOR of a 10-bit immediate into the low address bits, under a single enable bit. This equals an addition only when the base is aligned so that the bits the immediate covers are zero. The block has no carry chain.

The 4-bit window can only be read. A store aimed at it raises an error flag, and the write enable stays low. The block has three registered stages: it captures the inputs, applies the XOR, then translates the address.

Top module: `win_addr_xlat`

## Requirements
- R1: `width_o` equals the window bits [15:14] of the offset address. The codes are 0 for 32-bit, 1 for 16-bit, 2 for 8-bit and 3 for 4-bit.
- R2: `word_o` is the offset address shifted right by `width_o` bits, truncated to 10 bits. This gives bits [9:0], [10:1], [11:2] or [12:3].
- R3: `lane_o` gives the element's position inside the word, taken from the low `width_o` bits of the offset address. The unused upper lane bits are zero, so `lane_o` is 0 in the 32-bit window.
- R4: When `xor_en_i` is 1, the offset address is the base with the immediate XORed into bits [9:0]. When `xor_en_i` is 0, the offset address is the base unchanged.
- R5: The XOR never changes the window bits [15:14].
- R6: A store (`store_i`=1) to the 4-bit window gives `ro_err_o`=1 and `wr_o`=0.
- R7: A store to any other window gives `wr_o`=1 and `ro_err_o`=0. A load gives `wr_o`=0 and `ro_err_o`=0.
- R8: Outputs are registered. They reflect the inputs sampled three rising clock edges earlier.
- R9: While `rst` is high, all outputs are zero.
- R10: Address bits above the element index field of a window (bits [13:10] for 32-bit, [13:11] for 16-bit, [13:12] for 8-bit, [13] for 4-bit) have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_i | input | 16 | Address register value |
| imm_i | input | 10 | Offset immediate |
| xor_en_i | input | 1 | Apply the immediate by XOR |
| store_i | input | 1 | 1 for a store, 0 for a load |
| word_o | output | 10 | Physical RAM word address |
| lane_o | output | 3 | Element position inside the word |
| width_o | output | 2 | Window / element width code |
| wr_o | output | 1 | Write permitted for this access |
| ro_err_o | output | 1 | Store to the read-only window |

## Verification
The bench draws random bases that span all four windows, with random immediates, XOR enables and load/store choices. This shows that every shift amount and lane width is selected by the window bits, and not by the lower bits. Directed cases cover the following:
- An aligned base with the XOR on, so the offset acts like an add.
- A misaligned base, so the XOR differs from an add.
- Junk in the bits above each index field, which must not change the result.
- Stores to the read-only window, checked against stores to the writable windows.

Outputs are compared every cycle against inputs delayed by three cycles. A wrong latency therefore shows up as a mismatch.

// File: rtl/wxl_pkg.sv
package wxl_pkg;
  localparam int ADDR_W  = 16;
  localparam int IMM_W   = 10;
  localparam int WORD_AW = 10;
  localparam int SEL_W   = 2;
  localparam int NUM_WIN = 1 << SEL_W;
  localparam int LANE_W  = NUM_WIN - 1;

  typedef enum logic [SEL_W-1:0] {
    WIN_W32 = 2'd0,
    WIN_W16 = 2'd1,
    WIN_W8  = 2'd2,
    WIN_W4  = 2'd3
  } win_e;
endpackage

// File: rtl/wxl_capture.sv
module wxl_capture #(
  parameter int ADDR_W = wxl_pkg::ADDR_W,
  parameter int IMM_W  = wxl_pkg::IMM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              xen_i,
  input  logic              st_i,
  output logic [ADDR_W-1:0] base_q,
  output logic [IMM_W-1:0]  imm_q,
  output logic              xen_q,
  output logic              st_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      imm_q  <= '0;
      xen_q  <= 1'b0;
      st_q   <= 1'b0;
    end else begin
      base_q <= base_i;
      imm_q  <= imm_i;
      xen_q  <= xen_i;
      st_q   <= st_i;
    end
  end
endmodule

// File: rtl/wxl_xor.sv
module wxl_xor #(
  parameter int ADDR_W = wxl_pkg::ADDR_W,
  parameter int IMM_W  = wxl_pkg::IMM_W,
  parameter int SEL_W  = wxl_pkg::SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              xen_i,
  input  logic              st_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic              st_q
);
  localparam int PAD_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] mask;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    mask   = xen_i ? {{PAD_W{1'b0}}, imm_i} : '0;
    addr_d = base_i ^ mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      st_q   <= 1'b0;
    end else begin
      addr_q <= addr_d;
      st_q   <= st_i;
    end
  end

  // R4
  xor_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(xen_i) |-> addr_q == $past(base_i));
  // R5
  win_keep_chk: assert property (@(posedge clk) disable iff (rst)
    addr_q[ADDR_W-1 -: SEL_W] == $past(base_i[ADDR_W-1 -: SEL_W]));
endmodule

// File: rtl/wxl_translate.sv
module wxl_translate
  import wxl_pkg::*;
#(
  parameter int ADDR_W  = wxl_pkg::ADDR_W,
  parameter int WORD_AW = wxl_pkg::WORD_AW,
  parameter int SEL_W   = wxl_pkg::SEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               st_i,
  output logic [WORD_AW-1:0] word_q,
  output logic [(1<<SEL_W)-2:0] lane_q,
  output logic [SEL_W-1:0]   win_q,
  output logic               wr_q,
  output logic               ro_q
);
  localparam int NWIN  = 1 << SEL_W;
  localparam int LW    = NWIN - 1;
  localparam int MAXSH = NWIN - 1;

  logic [SEL_W-1:0]   sel;
  logic [WORD_AW-1:0] word_d;
  logic [LW-1:0]      lane_d;
  logic               ro_d;
  logic               wr_d;

  assign sel = addr_i[ADDR_W-1 -: SEL_W];

  // one mux per word bit picks the shifted source bit
  for (genvar i = 0; i < WORD_AW; i++) begin : g_word
    logic [NWIN-1:0] cand;
    for (genvar s = 0; s < NWIN; s++) begin : g_src
      if (i + s < ADDR_W - SEL_W) begin : g_in
        assign cand[s] = addr_i[i+s];
      end else begin : g_zero
        assign cand[s] = 1'b0;
      end
    end
    assign word_d[i] = cand[sel];
  end

  // lane bit k exists only when the window shift exceeds k
  for (genvar k = 0; k < LW; k++) begin : g_lane
    assign lane_d[k] = (int'(sel) > k) ? addr_i[k] : 1'b0;
  end

  always_comb begin
    ro_d = st_i && (sel == SEL_W'(MAXSH));
    wr_d = st_i && !ro_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      lane_q <= '0;
      win_q  <= '0;
      wr_q   <= 1'b0;
      ro_q   <= 1'b0;
    end else begin
      word_q <= word_d;
      lane_q <= lane_d;
      win_q  <= sel;
      wr_q   <= wr_d;
      ro_q   <= ro_d;
    end
  end

  // R6
  ro_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    ro_q |-> (!wr_q && win_q == WIN_W4));
  // R7
  wr_window_chk: assert property (@(posedge clk) disable iff (rst)
    wr_q |-> win_q != WIN_W4);
  // R3
  lane_w32_chk: assert property (@(posedge clk) disable iff (rst)
    win_q == WIN_W32 |-> lane_q == '0);
  // R7
  store_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $past(st_i) |-> $onehot({wr_q, ro_q}));
endmodule

// File: rtl/win_addr_xlat.sv
module win_addr_xlat
  import wxl_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   base_i,
  input  logic [IMM_W-1:0]    imm_i,
  input  logic                xor_en_i,
  input  logic                store_i,
  output logic [WORD_AW-1:0]  word_o,
  output logic [LANE_W-1:0]   lane_o,
  output logic [SEL_W-1:0]    width_o,
  output logic                wr_o,
  output logic                ro_err_o
);
  logic [ADDR_W-1:0] s0_base;
  logic [IMM_W-1:0]  s0_imm;
  logic              s0_xen;
  logic              s0_st;
  logic [ADDR_W-1:0] s1_addr;
  logic              s1_st;

  wxl_capture #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) i_cap (
    .clk(clk), .rst(rst),
    .base_i(base_i), .imm_i(imm_i), .xen_i(xor_en_i), .st_i(store_i),
    .base_q(s0_base), .imm_q(s0_imm), .xen_q(s0_xen), .st_q(s0_st)
  );

  wxl_xor #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .SEL_W(SEL_W)) i_xor (
    .clk(clk), .rst(rst),
    .base_i(s0_base), .imm_i(s0_imm), .xen_i(s0_xen), .st_i(s0_st),
    .addr_q(s1_addr), .st_q(s1_st)
  );

  wxl_translate #(.ADDR_W(ADDR_W), .WORD_AW(WORD_AW), .SEL_W(SEL_W)) i_xl (
    .clk(clk), .rst(rst),
    .addr_i(s1_addr), .st_i(s1_st),
    .word_q(word_o), .lane_q(lane_o), .win_q(width_o),
    .wr_q(wr_o), .ro_q(ro_err_o)
  );

  // R9
  rst_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (word_o == '0 && !wr_o && !ro_err_o));
endmodule

// File: tb/test_win_addr_xlat.sv
module test_win_addr_xlat;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] base_i = '0;
  logic [9:0]  imm_i = '0;
  logic        xor_en_i = 1'b0;
  logic        store_i = 1'b0;
  logic [9:0]  word_o;
  logic [2:0]  lane_o;
  logic [1:0]  width_o;
  logic        wr_o;
  logic        ro_err_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] h_base [3];
  logic [9:0]  h_imm  [3];
  logic        h_xen  [3];
  logic        h_st   [3];
  bit          h_vld  [3];

  always #2.5 clk = ~clk;

  win_addr_xlat i_win_addr_xlat (
    .clk(clk), .rst(rst), .base_i(base_i), .imm_i(imm_i),
    .xor_en_i(xor_en_i), .store_i(store_i),
    .word_o(word_o), .lane_o(lane_o), .width_o(width_o),
    .wr_o(wr_o), .ro_err_o(ro_err_o)
  );

  function automatic logic [15:0] eff_addr(logic [15:0] b, logic [9:0] m, logic x);
    return x ? (b ^ {6'd0, m}) : b;
  endfunction

  function automatic logic [9:0] exp_word(logic [15:0] a);
    logic [12:0] idx;
    case (a[15:14])
      2'd0: return a[9:0];
      2'd1: return a[10:1];
      2'd2: return a[11:2];
      default: begin idx = a[12:0]; return idx[12:3]; end
    endcase
  endfunction

  function automatic logic [2:0] exp_lane(logic [15:0] a);
    case (a[15:14])
      2'd0: return 3'd0;
      2'd1: return {2'd0, a[0]};
      2'd2: return {1'b0, a[1:0]};
      default: return a[2:0];
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_oldest();
    logic [15:0] a;
    bit ro, wr;
    if (!h_vld[2]) return;
    a  = eff_addr(h_base[2], h_imm[2], h_xen[2]);
    ro = h_st[2] && (a[15:14] == 2'd3);
    wr = h_st[2] && !ro;
    chk(width_o == a[15:14], "R1 R5 width", width_o, a[15:14]);
    chk(word_o == exp_word(a), "R2 R4 R8 R10 word", word_o, exp_word(a));
    chk(lane_o == exp_lane(a), "R3 lane", lane_o, exp_lane(a));
    chk(ro_err_o == ro, "R6 R7 ro_err", ro_err_o, ro);
    chk(wr_o == wr, "R6 R7 wr", wr_o, wr);
  endtask

  task automatic step(logic [15:0] b, logic [9:0] m, logic x, logic s);
    @(negedge clk);
    compare_oldest();
    for (int k = 2; k > 0; k--) begin
      h_base[k] = h_base[k-1]; h_imm[k] = h_imm[k-1];
      h_xen[k] = h_xen[k-1]; h_st[k] = h_st[k-1]; h_vld[k] = h_vld[k-1];
    end
    h_base[0] = b; h_imm[0] = m; h_xen[0] = x; h_st[0] = s; h_vld[0] = 1'b1;
    base_i = b; imm_i = m; xor_en_i = x; store_i = s;
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5EED);
    for (int k = 0; k < 3; k++) h_vld[k] = 1'b0;
    base_i = 16'hFFFF; imm_i = 10'h3FF; xor_en_i = 1'b1; store_i = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk(word_o == 0, "R9 word", word_o, 0);
    chk(lane_o == 0, "R9 lane", lane_o, 0);
    chk(width_o == 0, "R9 width", width_o, 0);
    chk(wr_o == 0, "R9 wr", wr_o, 0);
    chk(ro_err_o == 0, "R9 ro_err", ro_err_o, 0);
    rst = 1'b0;

    // R2 R3 each window, no offset
    step(16'h0123, 10'h0, 1'b0, 1'b0);
    step(16'h4123, 10'h0, 1'b0, 1'b0);
    step(16'h8123, 10'h0, 1'b0, 1'b0);
    step(16'hC123, 10'h0, 1'b0, 1'b0);
    // R4 aligned base: xor behaves as add
    step(16'h8400, 10'h3F, 1'b1, 1'b0);
    // R4 misaligned base: xor differs from add
    step(16'h0007, 10'h001, 1'b1, 1'b0);
    // R4 enable low ignores immediate
    step(16'h4055, 10'h3FF, 1'b0, 1'b0);
    // R10 junk above index field
    step(16'h3C21, 10'h0, 1'b0, 1'b0);
    step(16'h7821, 10'h0, 1'b0, 1'b0);
    step(16'hB021, 10'h0, 1'b0, 1'b0);
    step(16'hE021, 10'h0, 1'b0, 1'b0);
    // R6 R7 stores per window
    step(16'hC00F, 10'h0, 1'b0, 1'b1);
    step(16'h000F, 10'h0, 1'b0, 1'b1);
    step(16'h400F, 10'h0, 1'b0, 1'b1);
    step(16'h800F, 10'h0, 1'b0, 1'b1);
    step(16'hFFFF, 10'h3FF, 1'b1, 1'b1);
    // random mix
    for (int n = 0; n < 2000; n++)
      step(16'($urandom), 10'($urandom), 1'($urandom), 1'($urandom));
    for (int n = 0; n < 3; n++) step(16'h0, 10'h0, 1'b0, 1'b0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule